// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Idle-Line Detection

This block receives asynchronous serial characters on a single line. It oversamples the line 16 times per bit and decides each bit by a majority vote. It assembles either 8-bit or 9-bit characters, shifted in least-significant bit first. A receive-full flag reports each accepted character and holds it in a data register until the data is read.

Alongside the character path, the block counts mark (logic 1) bit times on the line. It raises an idle flag once the count reaches one whole frame. Two counting disciplines are available:
- **Early:** every mark bit counts, including the stop bit and any trailing 1 data bits.
- **Strict:** counting starts only after a stop bit has been accepted.

A wake-hold input keeps every flag from being set while it is high. An enable gates the idle flag onto an interrupt line.

Software clears the flags with a status read followed by a data read. After it is cleared, the idle flag stays disarmed until another character has been accepted. A long silence on the line therefore interrupts once.

Top module: `uart_idle_rx`

## Requirements
- R1: A frame is one 0 start bit, then data bits LSB first, then one 1 stop bit. There are 8 data bits when `nine_bits`=0 and 9 when `nine_bits`=1. A valid stop bit sets `rx_full` and loads `rx_data`. In 8-bit frames, `rx_data[8]` reads 0. A 0 stop bit loads nothing.
- R2: Each bit is the majority of samples 7, 8 and 9 out of 16, counted from the detected falling edge. A start bit whose vote is 1 is dropped, and the receiver goes back to hunting.
- R3: The idle threshold is one frame length in bit times: 10 when `nine_bits`=0 and 11 when `nine_bits`=1. Reaching it sets `idle_flag`.
- R4: With `idle_long`=0, every mark bit time counts, including stop bits and trailing 1 data bits. In 8-bit frames, an all-ones character followed by a single extra mark bit sets `idle_flag`.
- R5: With `idle_long`=1, only mark bits that follow an accepted stop bit count. A full frame of marks after the stop bit is needed before `idle_flag` sets.
- R6: Any bit time decided as 0 resets the mark count to zero. This includes start bits and 0 data bits.
- R7: `irq` is high exactly when `idle_flag` is high and `idle_ie` is high.
- R8: A `stat_rd` pulse followed later by a `data_rd` pulse clears each flag that was set at the `stat_rd`. A `data_rd` without a preceding `stat_rd` clears nothing.
- R9: After reset, and after each clear, `idle_flag` cannot set until a character has been accepted. A long idle period therefore sets it only once.
- R10: While `rx_wake` is high, neither `rx_full` nor `idle_flag` can set, and `rx_data` is not loaded. A character received in that state does not re-arm idle detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial line, idle high |
| nine_bits | input | 1 | 0: 8 data bits, 1: 9 data bits |
| idle_long | input | 1 | 0: early idle counting, 1: counting starts after a stop bit |
| idle_ie | input | 1 | Idle interrupt enable |
| rx_wake | input | 1 | Wake hold: blocks setting of all flags |
| stat_rd | input | 1 | One-cycle status read strobe |
| data_rd | input | 1 | One-cycle data read strobe |
| rx_data | output | 9 | Last accepted character |
| rx_full | output | 1 | Character accepted and not yet cleared |
| idle_flag | output | 1 | Idle line detected |
| irq | output | 1 | Idle interrupt request |

## Verification
The hardest case to reach from the ports is a second idle event. The idle flag must first be cleared by the two-read sequence and then re-armed by a character accepted with wake-hold low. Stray reads, wake-hold toggles and mode changes are all likely to leave the flag disarmed or uncleared.

The stimulus therefore has two parts:
- **Directed sequences:** these walk each counting mode through its exact threshold. Each one clears the flag, sends a fresh character, then counts mark bits one at a time.
- **Random traffic:** the random part mixes frames, gaps, false starts, bad stop bits, reads and control changes. A bit-level model follows it and is compared with the outputs in every bit time.

// File: rtl/uirx_pkg.sv
package uirx_pkg;

  typedef enum logic [1:0] {
    RX_HUNT  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  localparam int unsigned DATA_MAX  = 9;
  localparam int unsigned DATA_MIN  = 8;
  localparam int unsigned FRAME_MAX = DATA_MAX + 2;
  localparam int unsigned FRAME_MIN = DATA_MIN + 2;
  localparam int unsigned CNT_W     = $clog2(FRAME_MAX + 1);
  localparam int unsigned IDX_W     = $clog2(DATA_MAX);

endpackage

// File: rtl/uirx_rst_sync.sv
module uirx_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stg_q <= 2'b00;
    else           stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_out = stg_q[1];

endmodule

// File: rtl/uirx_prescale.sv
module uirx_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic samp_en
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    samp_en = (cnt_q == LAST);
    cnt_d   = samp_en ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/uirx_bitclk.sv
module uirx_bitclk #(
  parameter int unsigned OVS  = 16,
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_en,
  input  logic rx_in,
  input  logic hunting,
  output logic start_seen,
  output logic bit_done,
  output logic bit_val
);

  localparam int unsigned PW  = $clog2(OVS);
  localparam int unsigned MID = OVS / 2;
  localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);
  localparam logic [PW-1:0] PH_T0   = PW'(MID - 1);
  localparam logic [PW-1:0] PH_T1   = PW'(MID);
  localparam logic [PW-1:0] PH_T2   = PW'(MID + 1);

  logic [SYNC-1:0] sy_q;
  logic            rxs;
  logic [PW-1:0]   phase_q, phase_d;
  logic [1:0]      votes_q, votes_d;
  logic            tap;

  // line synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy_q <= '1;
    else        sy_q <= {sy_q[SYNC-2:0], rx_in};
  end
  assign rxs = sy_q[SYNC-1];

  always_comb begin
    tap        = (phase_q == PH_T0) || (phase_q == PH_T1) || (phase_q == PH_T2);
    start_seen = samp_en && hunting && !rxs;
    bit_done   = samp_en && !start_seen && (phase_q == PH_LAST);
    bit_val    = votes_q[1];
    phase_d    = phase_q;
    votes_d    = votes_q;
    if (start_seen) begin
      phase_d = PW'(1);
      votes_d = 2'd0;
    end else if (samp_en) begin
      phase_d = (phase_q == PH_LAST) ? '0 : phase_q + PW'(1);
      if (bit_done)        votes_d = 2'd0;
      else if (tap && rxs) votes_d = votes_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      votes_q <= 2'd0;
    end else begin
      phase_q <= phase_d;
      votes_q <= votes_d;
    end
  end

  AST_HUNT_BITS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_done && hunting) |-> bit_val);  // R2

endmodule

// File: rtl/uirx_framer.sv
module uirx_framer
  import uirx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_seen,
  input  logic                bit_done,
  input  logic                bit_val,
  input  logic                nine_bits,
  output logic                hunting,
  output logic                frame_ok,
  output logic [DATA_MAX-1:0] data_word
);

  rx_state_e           st_q, st_d;
  logic [IDX_W:0]      idx_q, idx_d;
  logic [DATA_MAX-1:0] sr_q, sr_d;
  logic [IDX_W:0]      idx_last;

  always_comb begin
    idx_last = nine_bits ? (IDX_W+1)'(DATA_MAX - 1) : (IDX_W+1)'(DATA_MIN - 1);
    st_d     = st_q;
    idx_d    = idx_q;
    sr_d     = sr_q;
    frame_ok = 1'b0;
    unique case (st_q)
      RX_HUNT: begin
        if (start_seen) st_d = RX_START;
      end
      RX_START: begin
        if (bit_done) begin
          st_d  = bit_val ? RX_HUNT : RX_DATA;
          idx_d = '0;
        end
      end
      RX_DATA: begin
        if (bit_done) begin
          sr_d = {bit_val, sr_q[DATA_MAX-1:1]};
          if (idx_q == idx_last) st_d = RX_STOP;
          else                   idx_d = idx_q + (IDX_W+1)'(1);
        end
      end
      RX_STOP: begin
        if (bit_done) begin
          st_d     = RX_HUNT;
          frame_ok = bit_val;
        end
      end
      default: st_d = RX_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_HUNT;
      idx_q <= '0;
      sr_q  <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      sr_q  <= sr_d;
    end
  end

  assign hunting   = (st_q == RX_HUNT);
  assign data_word = nine_bits ? sr_q : {1'b0, sr_q[DATA_MAX-1:1]};

  AST_START_LEAVES_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> (st_q == RX_START));  // R1

endmodule

// File: rtl/uirx_idle_det.sv
module uirx_idle_det
  import uirx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_done,
  input  logic bit_val,
  input  logic frame_ok,
  input  logic long_mode,
  input  logic nine_bits,
  input  logic wake,
  input  logic clr,
  output logic idle_flag
);

  logic [CNT_W-1:0] cnt_q, cnt_d, flen;
  logic             lgo_q, lgo_d;
  logic             armed_q, armed_d;
  logic             idle_q, idle_d;
  logic             hit, take;

  always_comb begin
    flen    = nine_bits ? CNT_W'(FRAME_MAX) : CNT_W'(FRAME_MIN);
    take    = frame_ok && !wake;
    cnt_d   = cnt_q;
    lgo_d   = lgo_q;
    armed_d = armed_q;
    idle_d  = idle_q;
    hit     = 1'b0;
    if (bit_done) begin
      if (!bit_val) begin
        cnt_d = '0;
        lgo_d = 1'b0;
      end else begin
        if ((!long_mode || lgo_q) && (cnt_q < flen)) begin
          cnt_d = cnt_q + CNT_W'(1);
          hit   = (cnt_d == flen);
        end
        if (frame_ok) lgo_d = 1'b1;
      end
    end
    if (take) armed_d = 1'b1;
    if (clr)  idle_d  = 1'b0;
    if (hit && (armed_q || take) && !wake) begin
      idle_d  = 1'b1;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      lgo_q   <= 1'b0;
      armed_q <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      lgo_q   <= lgo_d;
      armed_q <= armed_d;
      idle_q  <= idle_d;
    end
  end

  assign idle_flag = idle_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_MAX));  // R3
  AST_ZERO_RESETS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_done && !bit_val) |=> (cnt_q == '0));  // R6
  AST_IDLE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_q) |-> ($past(armed_q) || $past(frame_ok)));  // R9
  AST_IDLE_NOT_IN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_q) |-> !$past(wake));  // R10

endmodule

// File: rtl/uart_idle_rx.sv
module uart_idle_rx
  import uirx_pkg::*;
#(
  parameter int unsigned OVS  = 16,
  parameter int unsigned DIV  = 1,
  parameter int unsigned SYNC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_in,
  input  logic                nine_bits,
  input  logic                idle_long,
  input  logic                idle_ie,
  input  logic                rx_wake,
  input  logic                stat_rd,
  input  logic                data_rd,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                rx_full,
  output logic                idle_flag,
  output logic                irq
);

  logic                rst_n_s;
  logic                samp_en;
  logic                hunting, start_seen, bit_done, bit_val, frame_ok;
  logic [DATA_MAX-1:0] data_word;
  logic                idle_clr, take;

  logic [DATA_MAX-1:0] data_q, data_d;
  logic                full_q, full_d;
  logic                seen_full_q, seen_full_d;
  logic                seen_idle_q, seen_idle_d;

  uirx_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  if (DIV > 1) begin : g_div
    uirx_prescale #(.DIV(DIV)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .samp_en (samp_en)
    );
  end else begin : g_nodiv
    assign samp_en = 1'b1;
  end

  uirx_bitclk #(.OVS(OVS), .SYNC(SYNC)) u_bit (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .samp_en    (samp_en),
    .rx_in      (rx_in),
    .hunting    (hunting),
    .start_seen (start_seen),
    .bit_done   (bit_done),
    .bit_val    (bit_val)
  );

  uirx_framer u_frm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start_seen (start_seen),
    .bit_done   (bit_done),
    .bit_val    (bit_val),
    .nine_bits  (nine_bits),
    .hunting    (hunting),
    .frame_ok   (frame_ok),
    .data_word  (data_word)
  );

  uirx_idle_det u_idle (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .bit_done  (bit_done),
    .bit_val   (bit_val),
    .frame_ok  (frame_ok),
    .long_mode (idle_long),
    .nine_bits (nine_bits),
    .wake      (rx_wake),
    .clr       (idle_clr),
    .idle_flag (idle_flag)
  );

  // status and data register access
  always_comb begin
    take        = frame_ok && !rx_wake;
    idle_clr    = data_rd && seen_idle_q;
    data_d      = take ? data_word : data_q;
    full_d      = full_q;
    if (data_rd && seen_full_q) full_d = 1'b0;
    if (take)                   full_d = 1'b1;
    seen_full_d = seen_full_q;
    seen_idle_d = seen_idle_q;
    if (data_rd) begin
      seen_full_d = 1'b0;
      seen_idle_d = 1'b0;
    end
    if (stat_rd) begin
      seen_full_d = full_q;
      seen_idle_d = idle_flag;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      data_q      <= '0;
      full_q      <= 1'b0;
      seen_full_q <= 1'b0;
      seen_idle_q <= 1'b0;
    end else begin
      data_q      <= data_d;
      full_q      <= full_d;
      seen_full_q <= seen_full_d;
      seen_idle_q <= seen_idle_d;
    end
  end

  assign rx_data = data_q;
  assign rx_full = full_q;
  assign irq     = idle_flag && idle_ie;

  AST_FULL_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(full_q) |-> $past(frame_ok));  // R1
  AST_FULL_NOT_IN_WAKE: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(full_q) |-> !$past(rx_wake));  // R10
  AST_IDLE_CLR_SEQ: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(idle_flag) |-> ($past(data_rd) && $past(seen_idle_q)));  // R8
  AST_FULL_CLR_SEQ: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(full_q) |-> $past(data_rd));  // R8

endmodule

// File: tb/sim_uart_idle_rx.sv
module sim_uart_idle_rx;

  localparam int CLK_PERIOD = 10;
  localparam int OVS        = 16;

  logic       clk = 1'b0;
  logic       rst_n, rx_in, nine_bits, idle_long, idle_ie, rx_wake, stat_rd, data_rd;
  logic [8:0] rx_data;
  logic       rx_full, idle_flag, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit fin = 1'b0;

  // bench model state
  int         m_cnt, m_fst, m_bidx;
  bit         m_lgo, m_arm, m_idle, m_full, m_si, m_sf;
  logic [8:0] m_sr, m_data;
  // pending control change, applied mid-bit
  bit         ctl_pend, p_nine, p_long, p_ie, p_wake;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_idle_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .nine_bits(nine_bits),
    .idle_long(idle_long), .idle_ie(idle_ie), .rx_wake(rx_wake),
    .stat_rd(stat_rd), .data_rd(data_rd), .rx_data(rx_data),
    .rx_full(rx_full), .idle_flag(idle_flag), .irq(irq)
  );

  function automatic int frame_len(input bit nine);
    return nine ? 11 : 10;
  endfunction

  function automatic logic [8:0] word_of(input logic [8:0] sr, input bit nine);
    return nine ? sr : {1'b0, sr[8:1]};
  endfunction

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_bit(input bit v);
    bit fok = 1'b0;
    bit hit = 1'b0;
    case (m_fst)
      0: if (!v) begin m_fst = 1; m_bidx = 0; end
      1: begin
        m_sr = {v, m_sr[8:1]};
        if (m_bidx == (nine_bits ? 8 : 7)) m_fst = 2;
        else m_bidx++;
      end
      default: begin m_fst = 0; fok = v; end
    endcase
    if (!v) begin
      m_cnt = 0; m_lgo = 1'b0;
    end else begin
      if ((!idle_long || m_lgo) && m_cnt < frame_len(nine_bits)) begin
        m_cnt++;
        hit = (m_cnt == frame_len(nine_bits));
      end
      if (fok) m_lgo = 1'b1;
    end
    if (fok && !rx_wake) begin
      m_full = 1'b1; m_arm = 1'b1; m_data = word_of(m_sr, nine_bits);
    end
    if (hit && m_arm && !rx_wake) begin
      m_idle = 1'b1; m_arm = 1'b0;
    end
  endtask

  task automatic compare_all();
    chk("R3 idle_flag", {8'd0, idle_flag}, {8'd0, m_idle});
    chk("R1 rx_full", {8'd0, rx_full}, {8'd0, m_full});
    chk("R7 irq", {8'd0, irq}, {8'd0, m_idle && idle_ie});
    if (m_full) chk("R1 rx_data", rx_data, m_data);
  endtask

  // one bit time; glitch drives 0 only for the first 4 samples
  task automatic send_bit(input bit v, input bit rs, input bit rd, input bit glitch = 1'b0);
    rx_in = glitch ? 1'b0 : v;
    for (int k = 0; k < OVS; k++) begin
      @(negedge clk);
      if (glitch && k == 3) rx_in = 1'b1;
      if (k == 4 && rs) begin stat_rd = 1'b1; m_si = m_idle; m_sf = m_full; end
      if (k == 5) stat_rd = 1'b0;
      if (k == 6 && rd) begin
        data_rd = 1'b1;
        if (m_si) m_idle = 1'b0;
        if (m_sf) m_full = 1'b0;
        m_si = 1'b0; m_sf = 1'b0;
      end
      if (k == 7) data_rd = 1'b0;
      if (k == 8 && ctl_pend) begin
        nine_bits = p_nine; idle_long = p_long; idle_ie = p_ie; rx_wake = p_wake;
        ctl_pend = 1'b0;
      end
      if (k == 10) compare_all();
    end
    model_bit(v);
  endtask

  task automatic marks(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1, 1'b0, 1'b0);
  endtask

  task automatic set_ctrl(input bit nine, input bit lng, input bit ie, input bit wk);
    p_nine = nine; p_long = lng; p_ie = ie; p_wake = wk; ctl_pend = 1'b1;
    send_bit(1'b1, 1'b0, 1'b0);
  endtask

  task automatic send_frame(input logic [8:0] d, input bit bad_stop, input bit rnd_rd);
    int nb = nine_bits ? 9 : 8;
    send_bit(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < nb; i++)
      send_bit(d[i], rnd_rd && ($urandom % 7 == 0), rnd_rd && ($urandom % 7 == 0));
    send_bit(!bad_stop, 1'b0, 1'b0);
    if (bad_stop) send_bit(1'b1, 1'b0, 1'b0);
  endtask

  task automatic clear_flags();
    send_bit(1'b1, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; rx_in = 1'b1; nine_bits = 1'b0; idle_long = 1'b0; idle_ie = 1'b1;
    rx_wake = 1'b0; stat_rd = 1'b0; data_rd = 1'b0; ctl_pend = 1'b0;
    m_cnt = 0; m_fst = 0; m_bidx = 0; m_lgo = 0; m_arm = 0; m_idle = 0; m_full = 0;
    m_si = 0; m_sf = 0; m_sr = '0; m_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 reset idle_flag", {8'd0, idle_flag}, 9'd0);
    chk("R1 reset rx_full", {8'd0, rx_full}, 9'd0);
    chk("R7 reset irq", {8'd0, irq}, 9'd0);
    marks(24);
    chk("R9 no idle before first frame", {8'd0, idle_flag}, 9'd0);

    // R4: short mode, all-ones character plus one extra mark
    set_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
    send_frame(9'h0FF, 1'b0, 1'b0);
    marks(1);
    chk("R4 idle not yet after stop", {8'd0, idle_flag}, 9'd0);
    marks(1);
    chk("R4 idle after one extra mark", {8'd0, idle_flag}, 9'd1);
    chk("R7 irq with enable", {8'd0, irq}, 9'd1);
    chk("R1 rx_data all ones", rx_data, 9'h0FF);

    // R8: data read alone does not clear; status then data does
    send_bit(1'b1, 1'b0, 1'b1);
    chk("R8 data read alone keeps idle", {8'd0, idle_flag}, 9'd1);
    chk("R8 data read alone keeps full", {8'd0, rx_full}, 9'd1);
    clear_flags();
    chk("R8 sequence clears idle", {8'd0, idle_flag}, 9'd0);
    chk("R8 sequence clears full", {8'd0, rx_full}, 9'd0);

    // R9: long idle period gives no second event
    marks(30);
    chk("R9 no re-set without frame", {8'd0, idle_flag}, 9'd0);

    // R6: a 0 data bit restarts the count
    send_frame(9'h07F, 1'b0, 1'b0);
    marks(9);
    chk("R6 count restarted by 0 bit", {8'd0, idle_flag}, 9'd0);
    marks(1);
    chk("R6 idle after full run", {8'd0, idle_flag}, 9'd1);
    clear_flags();

    // R5: long mode waits for a full frame after the stop bit
    set_ctrl(1'b0, 1'b1, 1'b1, 1'b0);
    send_frame(9'h0FF, 1'b0, 1'b0);
    marks(2);
    chk("R5 long mode ignores pre-stop ones", {8'd0, idle_flag}, 9'd0);
    marks(8);
    chk("R5 long mode nine marks", {8'd0, idle_flag}, 9'd0);
    marks(1);
    chk("R5 long mode ten marks", {8'd0, idle_flag}, 9'd1);
    clear_flags();

    // R3: nine-bit frame threshold is 11
    set_ctrl(1'b1, 1'b0, 1'b1, 1'b0);
    send_frame(9'h1FF, 1'b0, 1'b0);
    marks(1);
    chk("R3 nine-bit ten ones", {8'd0, idle_flag}, 9'd0);
    marks(1);
    chk("R3 nine-bit eleven ones", {8'd0, idle_flag}, 9'd1);
    chk("R1 nine-bit data", rx_data, 9'h1FF);
    clear_flags();

    // R7: enable gates irq
    set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);
    send_frame(9'h0A5, 1'b0, 1'b0);
    marks(12);
    chk("R7 idle set", {8'd0, idle_flag}, 9'd1);
    chk("R7 irq masked", {8'd0, irq}, 9'd0);
    chk("R1 data 0A5", rx_data, 9'h0A5);
    set_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R7 irq unmasked", {8'd0, irq}, 9'd1);
    clear_flags();

    // R10: wake hold blocks flags and loading
    set_ctrl(1'b0, 1'b0, 1'b1, 1'b1);
    send_frame(9'h03C, 1'b0, 1'b0);
    marks(14);
    chk("R10 no full under wake", {8'd0, rx_full}, 9'd0);
    chk("R10 no idle under wake", {8'd0, idle_flag}, 9'd0);
    chk("R10 data not loaded", rx_data, 9'h0A5);
    set_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
    marks(12);
    chk("R10 wake frame did not arm", {8'd0, idle_flag}, 9'd0);
    send_frame(9'h03C, 1'b0, 1'b0);
    marks(12);
    chk("R10 full after wake low", {8'd0, rx_full}, 9'd1);
    chk("R10 idle after wake low", {8'd0, idle_flag}, 9'd1);
    clear_flags();

    // R2: short low pulse is a false start
    send_bit(1'b1, 1'b0, 1'b0, 1'b1);
    marks(12);
    chk("R2 false start rejected", {8'd0, rx_full}, 9'd0);
    chk("R2 no idle after false start", {8'd0, idle_flag}, 9'd0);

    // random traffic, checked each bit by the model
    for (int it = 0; it < 220; it++) begin
      if ($urandom % 5 == 0)
        set_ctrl($urandom % 2 == 0, $urandom % 2 == 0, $urandom % 3 != 0, $urandom % 6 == 0);
      for (int g = 0, n = $urandom % 14; g < n; g++)
        send_bit(1'b1, $urandom % 6 == 0, $urandom % 6 == 0);
      if ($urandom % 10 == 0 && m_fst == 0) send_bit(1'b1, 1'b0, 1'b0, 1'b1);
      send_frame(9'($urandom), $urandom % 12 == 0, 1'b1);
    end
    set_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
    marks(4);

    fin = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule